// File: doc/BRIEF.md
# Timed Unlock Guard for Protected Control Bits

This block keeps a group of sensitive control bits from being changed by a stray store. It watches a simple register bus (address, write data, write strobe and a per-cycle enable) for writes to one dedicated unlock register. A write of AAh there arms the guard. A write of 55h within the next three enabled cycles opens a short write window. While the window is open, an output named `wr_permit` is high. Other register logic in the chip uses it to qualify writes to its protected bits.

The window lasts exactly three enabled cycles after the 55h write and then closes by itself. Any unexpected write to the unlock register during the sequence or the window aborts it. A write of AAh always starts a fresh attempt. A small protected demo register at address 9Bh is included so that the qualifier can be seen doing its job. Reads of the unlock register return the value last written to it.

Top module: `ta_guard`

## Requirements
- R1: A synchronous active-high reset closes the window (`wr_permit` = 0) and returns the sequence to idle. After reset the unlock register (address C7h) reads FFh and the demo register (address 9Bh) reads 00h.
- R2: A write of AAh to C7h arms the guard. A write of 55h to C7h made 1, 2 or 3 enabled cycles later opens the window. A write of 55h made 4 or more enabled cycles later does not open it.
- R3: A write of 55h to C7h while the guard is not armed leaves the window closed.
- R4: While armed, a write to C7h of any value other than AAh or 55h returns the guard to idle. A write of AAh re-arms it with a fresh 3-cycle gap.
- R5: `wr_permit` is high in exactly the 3 enabled cycles that follow the cycle of the accepted 55h write, and low afterwards.
- R6: A write to 9Bh in a cycle where `wr_permit` is high loads the write data into the demo register.
- R7: Any write to C7h while the window is open closes it at once. If the value is AAh, the guard is also re-armed.
- R8: A write to 9Bh in a cycle where `wr_permit` is low is ignored, and the demo register keeps its value.
- R9: A read at C7h returns the last value written there. A read at 9Bh returns the demo register. A read at any other address returns 00h.
- R10: In a cycle with `ce` low, no write is taken, the sequence state and its counters hold, and the cycle does not count toward the 3-cycle limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Per-cycle enable; only enabled cycles act and count |
| bus_addr | input | 8 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| wr_permit | output | 1 | High while protected writes are allowed |
| demo_q | output | 8 | Current value of the protected demo register |

## Verification
The hardest situations to reach are the exact edges of the two bounded intervals. One is a 55h write on the last allowed gap cycle versus one cycle later. The other is a protected write on the third window cycle versus the fourth. Each of these is off by a single cycle from its neighbour. The directed tasks count idle steps explicitly to land on both sides of each limit. They repeat the unlock with `ce` dropped for several cycles, which shows that only enabled cycles consume the gap and the window. Aborts and restarts are driven by inserting a stray value, or a second AAh, between the two keys and inside an open window.

// File: rtl/ta_pkg.sv
package ta_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARMED = 2'd1,
    SQ_OPEN  = 2'd2
  } seq_state_e;

  // Width needed to hold the larger of two interval lengths
  function automatic int unsigned span_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // True when a down-counter stands on the last cycle of its interval
  function automatic logic is_last_tick(input int unsigned remaining);
    return remaining == 1;
  endfunction

endpackage

// File: rtl/ta_bus_decode.sv
module ta_bus_decode #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hC7,
  parameter logic [ADDR_W-1:0] DEMO_ADDR = 8'h9B
) (
  input  logic              ce,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] key_rd,
  input  logic [DATA_W-1:0] demo_rd,
  output logic              key_wr,
  output logic              demo_wr_req,
  output logic [DATA_W-1:0] bus_rdata
);

  logic hit_key;
  logic hit_demo;

  assign hit_key     = (bus_addr == KEY_ADDR);
  assign hit_demo    = (bus_addr == DEMO_ADDR);
  assign key_wr      = ce && bus_we && hit_key;
  assign demo_wr_req = ce && bus_we && hit_demo;

  always_comb begin
    if (hit_key)       bus_rdata = key_rd;
    else if (hit_demo) bus_rdata = demo_rd;
    else               bus_rdata = '0;
  end

endmodule

// File: rtl/ta_key_reg.sv
module ta_key_reg #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RST_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] key_q
);

  always_ff @(posedge clk) begin
    if (rst)         key_q <= RST_VAL;
    else if (key_wr) key_q <= wdata;
  end

  AST_KEY_READBACK: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> (key_q == $past(wdata))); // R9

  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !key_wr |=> $stable(key_q)); // R9

endmodule

// File: rtl/ta_seq_fsm.sv
module ta_seq_fsm
  import ta_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_ARM  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_OPEN = 8'h55,
  parameter int GAP_LIM = 3,
  parameter int WIN_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              permit,
  output logic              ev_arm,
  output logic              ev_unlock,
  output logic              ev_abort,
  output logic              ev_expire
);

  localparam int CNT_W = span_width(GAP_LIM, WIN_LEN);
  localparam logic [CNT_W-1:0] GAP_INIT = CNT_W'(GAP_LIM);
  localparam logic [CNT_W-1:0] WIN_INIT = CNT_W'(WIN_LEN);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic is_arm_val;
  logic is_open_val;
  logic last_tick;

  assign is_arm_val  = (wdata == KEY_ARM);
  assign is_open_val = (wdata == KEY_OPEN);
  assign last_tick   = is_last_tick(int'(cnt_q));

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    ev_arm    = 1'b0;
    ev_unlock = 1'b0;
    ev_abort  = 1'b0;
    ev_expire = 1'b0;
    if (ce) begin
      unique case (state_q)
        SQ_IDLE: begin
          if (key_wr && is_arm_val) begin
            state_d = SQ_ARMED;
            cnt_d   = GAP_INIT;
            ev_arm  = 1'b1;
          end
        end
        SQ_ARMED: begin
          if (key_wr) begin
            if (is_open_val) begin
              state_d   = SQ_OPEN;
              cnt_d     = WIN_INIT;
              ev_unlock = 1'b1;
            end else if (is_arm_val) begin
              cnt_d  = GAP_INIT;
              ev_arm = 1'b1;
            end else begin
              state_d  = SQ_IDLE;
              cnt_d    = '0;
              ev_abort = 1'b1;
            end
          end else if (last_tick) begin
            state_d   = SQ_IDLE;
            cnt_d     = '0;
            ev_expire = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        SQ_OPEN: begin
          if (key_wr) begin
            if (is_arm_val) begin
              state_d = SQ_ARMED;
              cnt_d   = GAP_INIT;
              ev_arm  = 1'b1;
            end else begin
              state_d  = SQ_IDLE;
              cnt_d    = '0;
              ev_abort = 1'b1;
            end
          end else if (last_tick) begin
            state_d   = SQ_IDLE;
            cnt_d     = '0;
            ev_expire = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          state_d = SQ_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign permit = (state_q == SQ_OPEN);

  // Checker counter: enabled cycles spent in the open window
  logic [CNT_W:0] open_run_q;
  always_ff @(posedge clk) begin
    if (rst)                       open_run_q <= '0;
    else if (state_q != SQ_OPEN)   open_run_q <= '0;
    else if (ce)                   open_run_q <= open_run_q + 1'b1;
  end

  AST_WIN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    permit |-> (open_run_q < (CNT_W+1)'(WIN_LEN))); // R5

  AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (rst)
    ev_unlock |=> permit); // R2

  AST_NO_OPEN_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_IDLE) |=> !permit); // R3

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ce && key_wr && state_q == SQ_ARMED && !is_arm_val && !is_open_val)
      |=> (state_q == SQ_IDLE)); // R4

  AST_KEY_CLOSES_WIN: assert property (@(posedge clk) disable iff (rst)
    (ce && key_wr && permit) |=> !permit); // R7

  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(state_q) && $stable(cnt_q))); // R10

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_arm, ev_unlock, ev_abort, ev_expire})); // R4

endmodule

// File: rtl/ta_demo_reg.sv
module ta_demo_reg #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              permit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic wr_ok;
  assign wr_ok = wr_req && permit;

  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (wr_ok) q <= wdata;
  end

  AST_DEMO_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !permit |=> $stable(q)); // R8

  AST_DEMO_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr_req && permit) |=> (q == $past(wdata))); // R6

endmodule

// File: rtl/ta_guard.sv
module ta_guard #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hC7,
  parameter logic [ADDR_W-1:0] DEMO_ADDR = 8'h9B,
  parameter logic [DATA_W-1:0] KEY_ARM   = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_OPEN  = 8'h55,
  parameter logic [DATA_W-1:0] KEY_RST   = 8'hFF,
  parameter int GAP_LIM = 3,
  parameter int WIN_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wr_permit,
  output logic [DATA_W-1:0] demo_q
);

  logic              key_wr;
  logic              demo_wr_req;
  logic [DATA_W-1:0] key_q;
  logic              ev_arm, ev_unlock, ev_abort, ev_expire;

  ta_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(KEY_ADDR), .DEMO_ADDR(DEMO_ADDR)
  ) u_dec (
    .ce(ce), .bus_addr(bus_addr), .bus_we(bus_we),
    .key_rd(key_q), .demo_rd(demo_q),
    .key_wr(key_wr), .demo_wr_req(demo_wr_req), .bus_rdata(bus_rdata)
  );

  ta_key_reg #(.DATA_W(DATA_W), .RST_VAL(KEY_RST)) u_key (
    .clk(clk), .rst(rst), .key_wr(key_wr), .wdata(bus_wdata), .key_q(key_q)
  );

  ta_seq_fsm #(
    .DATA_W(DATA_W), .KEY_ARM(KEY_ARM), .KEY_OPEN(KEY_OPEN),
    .GAP_LIM(GAP_LIM), .WIN_LEN(WIN_LEN)
  ) u_seq (
    .clk(clk), .rst(rst), .ce(ce), .key_wr(key_wr), .wdata(bus_wdata),
    .permit(wr_permit), .ev_arm(ev_arm), .ev_unlock(ev_unlock),
    .ev_abort(ev_abort), .ev_expire(ev_expire)
  );

  ta_demo_reg #(.DATA_W(DATA_W), .RST_VAL('0)) u_demo (
    .clk(clk), .rst(rst), .wr_req(demo_wr_req), .permit(wr_permit),
    .wdata(bus_wdata), .q(demo_q)
  );

  AST_EXPIRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (ev_expire && wr_permit) |=> !wr_permit); // R5

  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    ev_abort |=> !wr_permit); // R4

  AST_ARM_NO_PERMIT: assert property (@(posedge clk) disable iff (rst)
    ev_arm |=> !wr_permit); // R7

endmodule

// File: tb/tb_ta_guard.sv
module tb_ta_guard;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       ce;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic [7:0] bus_rdata;
  logic       wr_permit;
  logic [7:0] demo_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ta_guard dut (
    .clk(clk), .rst(rst), .ce(ce), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .wr_permit(wr_permit), .demo_q(demo_q)
  );

  localparam logic [7:0] A_KEY  = 8'hC7;
  localparam logic [7:0] A_DEMO = 8'h9B;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: inputs driven at a falling edge, result visible at the next falling edge
  task automatic step(input logic en, input logic we, input logic [7:0] a, input logic [7:0] d);
    ce = en; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; ce = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b1, 1'b0, 8'h00, 8'h00);
    step(1'b1, 1'b0, 8'h00, 8'h00);
    rst = 1'b0;
  endtask

  task automatic read_at(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    check("R1 permit", {7'd0, wr_permit}, 8'h00);
    read_at(A_KEY, v);  check("R1 key reads FF", v, 8'hFF);
    read_at(A_DEMO, v); check("R1 demo reads 00", v, 8'h00);
  endtask

  task automatic t_locked_write();
    step(1'b1, 1'b1, A_DEMO, 8'h3C);
    check("R8 locked demo write", demo_q, 8'h00);
    step(1'b1, 1'b1, A_KEY, 8'h55);
    check("R3 lone 55h", {7'd0, wr_permit}, 8'h00);
  endtask

  task automatic t_unlock_gap1();
    do_reset();
    step(1'b1, 1'b1, A_KEY, 8'hAA);
    step(1'b1, 1'b1, A_KEY, 8'h55);
    check("R2 gap1 opens", {7'd0, wr_permit}, 8'h01);
    step(1'b1, 1'b1, A_DEMO, 8'h5A);
    check("R6 demo load", demo_q, 8'h5A);
  endtask

  task automatic t_gap_edges();
    do_reset();
    step(1'b1, 1'b1, A_KEY, 8'hAA);
    idle(2);
    step(1'b1, 1'b1, A_KEY, 8'h55);
    check("R2 gap3 opens", {7'd0, wr_permit}, 8'h01);
    do_reset();
    step(1'b1, 1'b1, A_KEY, 8'hAA);
    idle(3);
    step(1'b1, 1'b1, A_KEY, 8'h55);
    check("R2 gap4 stays shut", {7'd0, wr_permit}, 8'h00);
  endtask

  task automatic t_window_len();
    do_reset();
    step(1'b1, 1'b1, A_KEY, 8'hAA);
    step(1'b1, 1'b1, A_KEY, 8'h55);
    idle(2);
    check("R5 third cycle open", {7'd0, wr_permit}, 8'h01);
    step(1'b1, 1'b1, A_DEMO, 8'h77);
    check("R6 write on third cycle", demo_q, 8'h77);
    check("R5 closed after three", {7'd0, wr_permit}, 8'h00);
    step(1'b1, 1'b1, A_DEMO, 8'h11);
    check("R8 write after window", demo_q, 8'h77);
  endtask

  task automatic t_abort_restart();
    do_reset();
    step(1'b1, 1'b1, A_KEY, 8'hAA);
    step(1'b1, 1'b1, A_KEY, 8'h12);
    step(1'b1, 1'b1, A_KEY, 8'h55);
    check("R4 stray value aborts", {7'd0, wr_permit}, 8'h00);
    step(1'b1, 1'b1, A_KEY, 8'hAA);
    idle(2);
    step(1'b1, 1'b1, A_KEY, 8'hAA);
    idle(2);
    step(1'b1, 1'b1, A_KEY, 8'h55);
    check("R4 second AAh restarts gap", {7'd0, wr_permit}, 8'h01);
  endtask

  task automatic t_close_in_window();
    do_reset();
    step(1'b1, 1'b1, A_KEY, 8'hAA);
    step(1'b1, 1'b1, A_KEY, 8'h55);
    step(1'b1, 1'b1, A_KEY, 8'hAA);
    check("R7 AAh closes window", {7'd0, wr_permit}, 8'h00);
    step(1'b1, 1'b1, A_KEY, 8'h55);
    check("R7 AAh re-armed", {7'd0, wr_permit}, 8'h01);
    step(1'b1, 1'b1, A_KEY, 8'h00);
    check("R7 other value closes", {7'd0, wr_permit}, 8'h00);
  endtask

  task automatic t_clock_enable();
    do_reset();
    step(1'b1, 1'b1, A_KEY, 8'hAA);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, A_KEY, 8'h01);
    step(1'b1, 1'b1, A_KEY, 8'h55);
    check("R10 gap ignores disabled cycles", {7'd0, wr_permit}, 8'h01);
    idle(2);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 8'h00, 8'h00);
    check("R10 window holds while disabled", {7'd0, wr_permit}, 8'h01);
    step(1'b0, 1'b1, A_DEMO, 8'h99);
    check("R10 disabled write not taken", demo_q, 8'h00);
    idle(1);
    check("R10 window ends after third enabled", {7'd0, wr_permit}, 8'h00);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    do_reset();
    step(1'b1, 1'b1, A_KEY, 8'h3E);
    read_at(A_KEY, v);  check("R9 key readback", v, 8'h3E);
    read_at(8'h10, v);  check("R9 other address", v, 8'h00);
    rst = 1'b1; step(1'b1, 1'b0, 8'h00, 8'h00); rst = 1'b0;
    read_at(A_KEY, v);  check("R1 key after reset", v, 8'hFF);
  endtask

  task automatic t_reset_mid_window();
    do_reset();
    step(1'b1, 1'b1, A_KEY, 8'hAA);
    step(1'b1, 1'b1, A_KEY, 8'h55);
    rst = 1'b1; step(1'b1, 1'b0, 8'h00, 8'h00); rst = 1'b0;
    check("R1 reset closes window", {7'd0, wr_permit}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ce = 1'b1; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
    @(negedge clk);
    t_reset();
    t_locked_write();
    t_unlock_gap1();
    t_gap_edges();
    t_window_len();
    t_abort_restart();
    t_close_in_window();
    t_clock_enable();
    t_readback();
    t_reset_mid_window();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule